// File: doc/BRIEF.md
# Prescaled 8-bit PWM Generator

This block drives one pulse-width-modulated output pin from a small register port. A configuration word holds an 8-bit compare value, a polarity bit and a 3-bit power-of-two prescaler code. A separate register picks the timebase: either a slow tick or a fast system tick. Both arrive as single-cycle clock-enable strobes in the block's one clock domain. Every period lasts 256 counts of the prescaled timebase. The output is active while the period counter is below the compare value.

Software starts and stops the output by writing one-bits to a command register. Start and stop are separate bits. A status bit reports whether the generator is really running. It rises as the first period begins and falls only when the period in progress at a stop request has ended. Configuration written while running is held in a pending copy and moves into the working copy only at a period boundary, so no period is ever cut short or stretched.

The register map has four word addresses:
- 0: configuration
- 1: timebase select
- 2: commands
- 3: status

Top module: `tickpwm_top`

## Requirements
- R1: After reset the status bit (address 3, bit 0) reads 0, the configuration word (address 0) reads 0, and pwm_out is 1, which is the idle level for polarity 0.
- R2: With polarity bit 4 set and prescaler code 0, pwm_out is high for exactly cmp clock-enabled counts out of every 256. cmp is taken from bits 15:8 of the configuration word.
- R3: A compare value of 0 keeps the output inactive for the whole period. A compare value of 255 makes it active for 255 of 256 counts.
- R4: With polarity bit 4 clear, the output is inverted: it is low during the compare portion and high for the remaining 256 - cmp counts.
- R5: Prescaler bits 2:0 stretch each count to 2^code ticks. Code 7 behaves exactly like code 6.
- R6: Address 1 bit 0 selects the timebase: 0 selects slow_tick and 1 selects sys_tick. Ticks on the unselected input have no effect.
- R7: Writing address 2 with bit 0 set requests start, and with bit 1 set requests stop. If both bits are set in one write, stop wins.
- R8: After a start write, the status bit still reads 0 in the following cycle. It reads 1 one clock later, at which point the period counter and prescaler begin from zero.
- R9: After a stop write, the status bit stays 1 and the output keeps running until the current period ends. Then the status bit reads 0 and the output goes to its idle level.
- R10: Configuration written while running takes effect only at the next period start. The period in progress completes with the old values.
- R11: While stopped, pwm_out is held at the idle level of the written polarity: 0 when bit 4 is set and 1 when it is clear. The counter and prescaler are held at zero.
- R12: Address 0 reads back the configuration word as written, with cmp at bits 15:8, polarity at bit 4 and the code at bits 2:0, including code 7. Address 1 reads back the select bit at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | Slow timebase clock-enable strobe |
| sys_tick | input | 1 | System timebase clock-enable strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write word address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 2 | Register read word address |
| rd_data | output | 16 | Register read data (combinational) |
| pwm_out | output | 1 | PWM output pin |

## Verification
The bench measures high time over whole periods for the extreme compare values, both polarities, a scaled code and the clamped code 7. A wrong shift or an unclamped code would give a period of twice or a quarter of the expected length. It rewrites the compare value and requests a stop in the middle of a period. A design without shadowing would let the new value leak into the current period, and one that stops at once would truncate it, so either error changes the measured count. Status is sampled in the cycle just after start, which catches a status bit that runs ahead of the output. A slow-source run with the system tick held low exposes a broken select, since the counter would either freeze or run too fast.

// File: rtl/tickpwm_pkg.sv
package tickpwm_pkg;

    localparam int CMP_W  = 8;
    localparam int PS_W   = 3;
    localparam int DATA_W = 16;

    // bit positions inside the configuration word
    localparam int CMP_LSB = 8;
    localparam int POL_BIT = 4;
    localparam int PS_LSB  = 0;

    // command bits at the command address
    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;

    typedef enum logic [1:0] {
        ADDR_CFG  = 2'd0,
        ADDR_SRC  = 2'd1,
        ADDR_CMD  = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [CMP_W-1:0] cmp;
        logic             pol;
        logic [PS_W-1:0]  ps;
    } pwm_cfg_t;

endpackage

// File: rtl/tickpwm_regs.sv
module tickpwm_regs
    import tickpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    input  logic              run_status,
    output logic [DATA_W-1:0] rd_data,
    output pwm_cfg_t          cfg_pend,
    output logic              src_sys,
    output logic              want_run
);

    typedef struct packed {
        pwm_cfg_t cfg;
        logic     src;
        logic     want;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CFG: begin
                    st_d.cfg.cmp = wr_data[CMP_LSB +: CMP_W];
                    st_d.cfg.pol = wr_data[POL_BIT];
                    st_d.cfg.ps  = wr_data[PS_LSB +: PS_W];
                end
                ADDR_SRC: st_d.src = wr_data[0];
                ADDR_CMD: begin
                    if (wr_data[CMD_STOP]) begin
                        st_d.want = 1'b0;
                    end else if (wr_data[CMD_START]) begin
                        st_d.want = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (reg_addr_e'(rd_addr))
            ADDR_CFG: begin
                rd_data[CMP_LSB +: CMP_W] = st_q.cfg.cmp;
                rd_data[POL_BIT]          = st_q.cfg.pol;
                rd_data[PS_LSB +: PS_W]   = st_q.cfg.ps;
            end
            ADDR_SRC:  rd_data[0] = st_q.src;
            ADDR_STAT: rd_data[0] = run_status;
            default:   rd_data = '0;
        endcase
    end

    assign cfg_pend = st_q.cfg;
    assign src_sys  = st_q.src;
    assign want_run = st_q.want;

endmodule

// File: rtl/tickpwm_prescale.sv
module tickpwm_prescale #(
    parameter int PS_W   = 3,
    parameter int PS_MAX = 6,
    localparam int DIV_W = PS_MAX + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [PS_W-1:0]  ps_code,
    output logic             advance,
    output logic [DIV_W-1:0] div_cnt
);

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } div_t;

    div_t st_d, st_q;
    logic [PS_W-1:0]  code_eff;
    logic [DIV_W-1:0] mask;

    // codes above the legal maximum are clamped
    assign code_eff = (ps_code > PS_W'(PS_MAX)) ? PS_W'(PS_MAX) : ps_code;

    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (i < int'(code_eff));
    end

    always_comb begin
        st_d    = st_q;
        advance = 1'b0;
        if (!run) begin
            st_d.div = '0;
        end else if (tick) begin
            advance  = ((st_q.div & mask) == mask);
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign div_cnt = st_q.div;

endmodule

// File: rtl/tickpwm_engine.sv
module tickpwm_engine
    import tickpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_run,
    input  logic             advance,
    input  pwm_cfg_t         cfg_pend,
    output logic             running,
    output logic [CMP_W-1:0] count,
    output pwm_cfg_t         cfg_work,
    output logic             pwm_out
);

    localparam logic [CMP_W-1:0] CNT_LAST = {CMP_W{1'b1}};

    typedef struct packed {
        logic             run;
        logic [CMP_W-1:0] cnt;
        pwm_cfg_t         cfg;
    } eng_t;

    eng_t st_d, st_q;
    logic wrap;
    logic active;

    always_comb begin
        st_d = st_q;
        wrap = st_q.run && advance && (st_q.cnt == CNT_LAST);
        if (!st_q.run) begin
            st_d.cnt = '0;
            st_d.cfg = cfg_pend;
            st_d.run = want_run;
        end else begin
            if (advance) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
            if (wrap) begin
                st_d.cfg = cfg_pend;
                st_d.run = want_run;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active   = st_q.run && (st_q.cnt < st_q.cfg.cmp);
    assign pwm_out  = st_q.cfg.pol ? active : !active;
    assign running  = st_q.run;
    assign count    = st_q.cnt;
    assign cfg_work = st_q.cfg;

endmodule

// File: rtl/tickpwm_top.sv
module tickpwm_top
    import tickpwm_pkg::*;
#(
    parameter int PS_MAX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              sys_tick,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              pwm_out
);

    localparam int DIV_W = PS_MAX + 1;

    pwm_cfg_t         cfg_pend;
    pwm_cfg_t         cfg_work;
    logic             src_sys;
    logic             want_run;
    logic             running;
    logic             tick_sel;
    logic             advance;
    logic [CMP_W-1:0] count;
    logic [DIV_W-1:0] div_cnt;

    always_comb begin
        tick_sel = src_sys ? sys_tick : slow_tick;
    end

    tickpwm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .run_status (running),
        .rd_data    (rd_data),
        .cfg_pend   (cfg_pend),
        .src_sys    (src_sys),
        .want_run   (want_run)
    );

    tickpwm_prescale #(
        .PS_W   (PS_W),
        .PS_MAX (PS_MAX)
    ) u_prescale (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (running),
        .tick    (tick_sel),
        .ps_code (cfg_work.ps),
        .advance (advance),
        .div_cnt (div_cnt)
    );

    tickpwm_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .want_run (want_run),
        .advance  (advance),
        .cfg_pend (cfg_pend),
        .running  (running),
        .count    (count),
        .cfg_work (cfg_work),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/tickpwm_checker.sv
module tickpwm_checker #(
    parameter int CMP_W = 8,
    parameter int DIV_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             running,
    input logic             advance,
    input logic [CMP_W-1:0] count,
    input logic [DIV_W-1:0] div_cnt,
    input logic [CMP_W-1:0] work_cmp,
    input logic             work_pol,
    input logic             pwm_out
);

    localparam logic [CMP_W-1:0] LAST = {CMP_W{1'b1}};

    // R11: stopped output sits at the idle level of the working polarity
    p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (pwm_out == !work_pol));

    // R8: a run begins with counter and divider at zero
    p_start_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (count == '0 && div_cnt == '0));

    // R9: running ends only right after the last count of a period advanced
    p_stop_boundary_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(running) |-> ($past(advance) && $past(count) == LAST));

    // R10: working compare value changes only across a period boundary
    p_shadow_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !(advance && count == LAST)) |=> $stable(work_cmp));

    // R5: the period counter moves only on a prescaled advance
    p_count_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !advance) |=> $stable(count));

    // R3: a zero compare value never produces the active level
    p_zero_inactive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (work_cmp == '0) |-> (pwm_out == !work_pol));

endmodule

bind tickpwm_top tickpwm_checker #(
    .CMP_W (tickpwm_pkg::CMP_W),
    .DIV_W (PS_MAX + 1)
) u_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .running  (running),
    .advance  (advance),
    .count    (count),
    .div_cnt  (div_cnt),
    .work_cmp (cfg_work.cmp),
    .work_pol (cfg_work.pol),
    .pwm_out  (pwm_out)
);

// File: tb/tickpwm_top_test.sv
`timescale 1ns/1ps
module tickpwm_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        sys_tick = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = 2'd3;
    logic [15:0] rd_data;
    logic        pwm_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    tickpwm_top uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .sys_tick  (sys_tick),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .pwm_out   (pwm_out)
    );

    // slow timebase: one strobe every fourth clock
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cfg_word(input int cmp, input bit pol, input int ps);
        return {8'(cmp), 3'b000, pol, 1'b0, 3'(ps)};
    endfunction

    task automatic reg_write(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int status();
        return int'(uut.rd_data[0] & (rd_addr == 2'd3));
    endfunction

    // stop and wait until the status bit clears
    task automatic stop_wait();
        reg_write(2'd2, 16'h0002);
        rd_addr = 2'd3;
        for (int i = 0; i < 20000 && rd_data[0]; i++) @(negedge clk);
    endtask

    // start, check the one-cycle status lag, then count high samples
    task automatic start_count(input string req, input int n, output int high);
        rd_addr = 2'd3;
        reg_write(2'd2, 16'h0001);
        check({req, "/R8 status lag"}, int'(rd_data[0]), 0);
        @(negedge clk);
        check({req, "/R8 status set"}, int'(rd_data[0]), 1);
        high = 0;
        for (int i = 0; i < n; i++) begin
            high += int'(pwm_out);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rd_addr = 2'd3;
        #1;
        check("R1 status", int'(rd_data[0]), 0);
        check("R1 pwm_out idle", int'(pwm_out), 1);
        rd_addr = 2'd0;
        #1;
        check("R1 cfg word", int'(rd_data), 0);
    endtask

    task automatic t_duty(input int cmp, input string req);
        int h;
        reg_write(2'd1, 16'h0001);
        reg_write(2'd0, cfg_word(cmp, 1'b1, 0));
        start_count(req, 256, h);
        check({req, " high count"}, h, cmp);
        stop_wait();
    endtask

    task automatic t_polarity();
        int h;
        reg_write(2'd0, cfg_word(64, 1'b0, 0));
        @(negedge clk);
        check("R11 idle pol0", int'(pwm_out), 1);
        start_count("R4", 256, h);
        check("R4 inverted high count", h, 192);
        stop_wait();
        reg_write(2'd0, cfg_word(64, 1'b1, 0));
        @(negedge clk);
        check("R11 idle pol1", int'(pwm_out), 0);
    endtask

    task automatic t_prescale();
        int h;
        reg_write(2'd0, cfg_word(64, 1'b1, 2));
        start_count("R5 code2", 1024, h);
        check("R5 code2 high count", h, 256);
        stop_wait();
        reg_write(2'd0, cfg_word(128, 1'b1, 7));
        rd_addr = 2'd0;
        #1;
        check("R12 cfg readback code7", int'(rd_data), int'(cfg_word(128, 1'b1, 7)));
        start_count("R5 code7", 16384, h);
        check("R5 code7 high count", h, 8192);
        stop_wait();
    endtask

    task automatic t_slow_source();
        int h;
        sys_tick = 1'b0;
        reg_write(2'd1, 16'h0000);
        rd_addr = 2'd1;
        #1;
        check("R12 src readback", int'(rd_data[0]), 0);
        reg_write(2'd0, cfg_word(32, 1'b1, 0));
        start_count("R6", 1024, h);
        check("R6 slow high count", h, 128);
        stop_wait();
        sys_tick = 1'b1;
        reg_write(2'd1, 16'h0001);
    endtask

    task automatic t_shadow_and_stop();
        int h;
        reg_write(2'd0, cfg_word(64, 1'b1, 0));
        start_count("R10", 0, h);
        h = 0;
        for (int i = 0; i < 256; i++) begin
            h += int'(pwm_out);
            if (i == 100) begin wr_en = 1'b1; wr_addr = 2'd0; wr_data = cfg_word(200, 1'b1, 0); end
            if (i == 101) wr_en = 1'b0;
            @(negedge clk);
        end
        check("R10 old value kept", h, 64);
        h = 0;
        for (int i = 0; i < 256; i++) begin
            h += int'(pwm_out);
            @(negedge clk);
        end
        check("R10 new value applied", h, 200);
        rd_addr = 2'd3;
        h = 0;
        for (int i = 0; i < 256; i++) begin
            h += int'(pwm_out);
            if (i == 100) begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = 16'h0002; end
            if (i == 101) wr_en = 1'b0;
            if (i == 150) check("R9 status held", int'(rd_data[0]), 1);
            @(negedge clk);
        end
        check("R9 period completed", h, 200);
        check("R9 status cleared", int'(rd_data[0]), 0);
        check("R9 output idle", int'(pwm_out), 0);
    endtask

    task automatic t_both_cmds();
        reg_write(2'd2, 16'h0003);
        repeat (3) @(negedge clk);
        rd_addr = 2'd3;
        #1;
        check("R7 stop wins status", int'(rd_data[0]), 0);
        check("R7 stop wins output", int'(pwm_out), 0);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_duty(64, "R2");
        t_duty(0, "R3 zero");
        t_duty(255, "R3 full");
        t_polarity();
        t_prescale();
        t_slow_source();
        t_shadow_and_stop();
        t_both_cmds();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            report();
        end
    end

endmodule